// File: doc/BRIEF.md
# Relative-Addressed Register Stack with Add Operations

This block keeps a small file of integer registers arranged as a circular stack. A top pointer moves through the physical entries, and every operand is named by its distance from the current top. Relative slot 0 is always the top. Relative slot i is physical entry (top + i) modulo the depth. Pushing moves the top one entry down and fills it. Popping empties the top and moves the pointer one entry up.

Besides push and pop, the block runs two-operand additions. Each addition always takes the top as one operand. The result goes to the top, to another relative slot, or to the slot below the top, and some additions pop afterwards. A caller sends one operation per cycle over a valid/ready handshake. The caller reads the stack back through a relative inspection port.

Every physical entry carries an occupancy tag. An operation that reads an empty slot raises an underflow pulse. A push onto an occupied slot raises an overflow pulse. When either pulse fires, the stack keeps its pointer, data and tags.

Top module: `rstk_file`

## Requirements
- R1: After synchronous reset, all entries are empty, `top_ptr` is 0, both error pulses are low, and `op_ready` is high.
- R2: A push (code 1) with the entry just below the top empty sets `top_ptr` to top-1 modulo the depth. It stores `op_mem` at the new relative slot 0, and each older value appears one relative slot deeper.
- R3: A push whose target entry (physical top-1) is already occupied raises `ovf_flag` for exactly one cycle. The pointer, data and tags are left unchanged.
- R4: A pop (code 2) on an occupied top empties that entry and sets `top_ptr` to top+1 modulo the depth.
- R5: Any operation whose operand slot is empty raises `unf_flag` for one cycle and leaves the stack unchanged. This applies to code 2, code 5 and codes 3, 4, 6, 7. The operand slots are slot 0 for codes 2 and 5, slots 0 and 1 for code 3, and slots 0 and `op_idx` for codes 4, 6 and 7. The two pulses are never high together.
- R6: Code 3 writes slot0+slot1 into slot 1, then pops, so the sum becomes the new slot 0.
- R7: Code 4 writes slot0+slot(`op_idx`) into slot `op_idx` and does not move the pointer.
- R8: Code 5 writes slot0+`op_mem` into slot 0 and does not move the pointer.
- R9: Code 6 writes slot0+slot(`op_idx`) into slot 0 and does not move the pointer.
- R10: Code 7 writes slot0+slot(`op_idx`) into slot `op_idx`, then pops. With `op_idx` 0, the sum is discarded and the operation acts as a plain pop.
- R11: All sums wrap modulo 2^DATA_W.
- R12: Each operation takes effect at the clock edge that accepts it, and the block accepts one operation per cycle. The inspection port is combinational on stored state. When `op_valid` is low, or for code 0, nothing changes and no pulse fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation can be accepted (high outside reset) |
| op_code | input | 3 | 0 none, 1 push, 2 pop, 3 add-pop, 4 add-into-slot, 5 add-memory, 6 add-into-top, 7 add-into-slot-pop |
| op_idx | input | 3 | Relative operand slot |
| op_mem | input | DATA_W | Memory operand / push value |
| peek_idx | input | 3 | Relative slot to inspect |
| peek_data | output | DATA_W | Inspected value, zero when empty |
| peek_full | output | 1 | Inspected slot occupied |
| top_ptr | output | 3 | Physical index of the top |
| ovf_flag | output | 1 | Overflow pulse for the previous operation |
| unf_flag | output | 1 | Underflow pulse for the previous operation |

## Verification
Each operation is driven on a falling edge and accepted on the next rising edge. The pointer, the stored entries and both error pulses are all registered at that edge, so their new values are due one cycle after the stimulus. The bench samples 1 ns after that rising edge and drops `op_valid` at the same moment, so the pulses are read in the only cycle they are high. Because the inspection port is combinational, the bench sweeps `peek_idx` over every relative slot within that same window. It compares each slot against a reference stack that it updates from the requirements.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    typedef enum logic [2:0] {
        OP_NOP         = 3'd0,
        OP_PUSH        = 3'd1,
        OP_POP         = 3'd2,
        OP_ADD_POP     = 3'd3,
        OP_ADD_IDX     = 3'd4,
        OP_ADD_MEM     = 3'd5,
        OP_ADD_TOP     = 3'd6,
        OP_ADD_IDX_POP = 3'd7
    } rstk_op_e;

    typedef enum logic [1:0] {
        DST_TOP   = 2'd0,
        DST_REL   = 2'd1,
        DST_NEXT  = 2'd2,
        DST_ABOVE = 2'd3
    } rstk_dst_e;

    typedef enum logic [1:0] {
        ADDEND_REL  = 2'd0,
        ADDEND_NEXT = 2'd1,
        ADDEND_MEM  = 2'd2
    } rstk_addend_e;

    typedef struct packed {
        logic         wr_en;
        logic         wr_sum;
        rstk_dst_e    dst;
        rstk_addend_e addend;
        logic         push;
        logic         pop;
        logic         ovf;
        logic         unf;
    } rstk_ctrl_t;

    function automatic logic op_pops(rstk_op_e op);
        return (op == OP_POP) || (op == OP_ADD_POP) || (op == OP_ADD_IDX_POP);
    endfunction

    function automatic logic op_uses_rel(rstk_op_e op);
        return (op == OP_ADD_IDX) || (op == OP_ADD_TOP) || (op == OP_ADD_IDX_POP);
    endfunction

endpackage

// File: rtl/rstk_addr.sv
module rstk_addr #(
    parameter int PTR_W = 3
) (
    input  logic [PTR_W-1:0] top,
    input  logic [PTR_W-1:0] rel_idx,
    input  logic [PTR_W-1:0] peek_idx,
    output logic [PTR_W-1:0] slot_top,
    output logic [PTR_W-1:0] slot_rel,
    output logic [PTR_W-1:0] slot_next,
    output logic [PTR_W-1:0] slot_above,
    output logic [PTR_W-1:0] slot_peek
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    // Depth is a power of two, so PTR_W-bit arithmetic wraps modulo depth.
    always_comb begin
        slot_top   = top;
        slot_rel   = top + rel_idx;
        slot_next  = top + ONE;
        slot_above = top - ONE;
        slot_peek  = top + peek_idx;
    end
endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
(
    input  logic       op_valid,
    input  rstk_op_e   op,
    input  logic       tag_top,
    input  logic       tag_rel,
    input  logic       tag_next,
    input  logic       tag_above,
    output rstk_ctrl_t ctrl
);
    logic ovf_c;
    logic unf_c;

    always_comb begin
        ovf_c = 1'b0;
        unf_c = 1'b0;
        unique case (op)
            OP_PUSH:        ovf_c = tag_above;
            OP_POP:         unf_c = !tag_top;
            OP_ADD_MEM:     unf_c = !tag_top;
            OP_ADD_POP:     unf_c = !tag_top || !tag_next;
            OP_ADD_IDX,
            OP_ADD_TOP,
            OP_ADD_IDX_POP: unf_c = !tag_top || !tag_rel;
            default:        ;
        endcase
    end

    always_comb begin
        ctrl        = '0;
        ctrl.dst    = DST_TOP;
        ctrl.addend = ADDEND_REL;
        ctrl.ovf    = op_valid && ovf_c;
        ctrl.unf    = op_valid && unf_c;
        if (op_valid && !ovf_c && !unf_c) begin
            unique case (op)
                OP_PUSH: begin
                    ctrl.wr_en = 1'b1;
                    ctrl.dst   = DST_ABOVE;
                    ctrl.push  = 1'b1;
                end
                OP_ADD_POP: begin
                    ctrl.wr_en  = 1'b1;
                    ctrl.wr_sum = 1'b1;
                    ctrl.dst    = DST_NEXT;
                    ctrl.addend = ADDEND_NEXT;
                end
                OP_ADD_IDX, OP_ADD_IDX_POP: begin
                    ctrl.wr_en  = 1'b1;
                    ctrl.wr_sum = 1'b1;
                    ctrl.dst    = DST_REL;
                end
                OP_ADD_MEM: begin
                    ctrl.wr_en  = 1'b1;
                    ctrl.wr_sum = 1'b1;
                    ctrl.addend = ADDEND_MEM;
                end
                OP_ADD_TOP: begin
                    ctrl.wr_en  = 1'b1;
                    ctrl.wr_sum = 1'b1;
                end
                default: ;
            endcase
            ctrl.pop = op_pops(op);
        end
    end
endmodule

// File: rtl/rstk_regs.sv
module rstk_regs #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [PTR_W-1:0]              wr_slot,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          clr_en,
    input  logic [PTR_W-1:0]              clr_slot,
    output logic [DEPTH-1:0][DATA_W-1:0]  data_q,
    output logic [DEPTH-1:0]              tag_q
);
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic hit_wr;
        logic hit_clr;
        assign hit_wr  = wr_en  && (wr_slot  == PTR_W'(e));
        assign hit_clr = clr_en && (clr_slot == PTR_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[e] <= '0;
                tag_q[e]  <= 1'b0;
            end else begin
                if (hit_wr)
                    data_q[e] <= wr_data;
                // A pop of the same entry wins over the write.
                if (hit_clr)
                    tag_q[e] <= 1'b0;
                else if (hit_wr)
                    tag_q[e] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rstk_file.sv
module rstk_file
    import rstk_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [2:0]        op_code,
    input  logic [PTR_W-1:0]  op_idx,
    input  logic [DATA_W-1:0] op_mem,
    input  logic [PTR_W-1:0]  peek_idx,
    output logic [DATA_W-1:0] peek_data,
    output logic              peek_full,
    output logic [PTR_W-1:0]  top_ptr,
    output logic              ovf_flag,
    output logic              unf_flag
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic [PTR_W-1:0]             ptr_q;
    logic [PTR_W-1:0]             s_top, s_rel, s_next, s_above, s_peek;
    logic [DEPTH-1:0][DATA_W-1:0] data_q;
    logic [DEPTH-1:0]             tag_q;
    rstk_ctrl_t                   ctrl;
    rstk_op_e                     op;
    logic [DATA_W-1:0]            addend, sum, wr_data;
    logic [PTR_W-1:0]             wr_slot;

    assign op = rstk_op_e'(op_code);

    rstk_addr #(.PTR_W(PTR_W)) u_addr (
        .top        (ptr_q),
        .rel_idx    (op_idx),
        .peek_idx   (peek_idx),
        .slot_top   (s_top),
        .slot_rel   (s_rel),
        .slot_next  (s_next),
        .slot_above (s_above),
        .slot_peek  (s_peek)
    );

    rstk_ctrl u_ctrl (
        .op_valid  (op_valid && !rst),
        .op        (op),
        .tag_top   (tag_q[s_top]),
        .tag_rel   (tag_q[s_rel]),
        .tag_next  (tag_q[s_next]),
        .tag_above (tag_q[s_above]),
        .ctrl      (ctrl)
    );

    always_comb begin
        unique case (ctrl.addend)
            ADDEND_NEXT: addend = data_q[s_next];
            ADDEND_MEM:  addend = op_mem;
            default:     addend = data_q[s_rel];
        endcase
        sum     = data_q[s_top] + addend;
        wr_data = ctrl.wr_sum ? sum : op_mem;
        unique case (ctrl.dst)
            DST_REL:   wr_slot = s_rel;
            DST_NEXT:  wr_slot = s_next;
            DST_ABOVE: wr_slot = s_above;
            default:   wr_slot = s_top;
        endcase
    end

    rstk_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctrl.wr_en),
        .wr_slot  (wr_slot),
        .wr_data  (wr_data),
        .clr_en   (ctrl.pop),
        .clr_slot (s_top),
        .data_q   (data_q),
        .tag_q    (tag_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            ovf_flag <= ctrl.ovf;
            unf_flag <= ctrl.unf;
            if (ctrl.push)
                ptr_q <= ptr_q - ONE;
            else if (ctrl.pop)
                ptr_q <= ptr_q + ONE;
        end
    end

    assign op_ready  = !rst;
    assign top_ptr   = ptr_q;
    assign peek_full = tag_q[s_peek];
    assign peek_data = tag_q[s_peek] ? data_q[s_peek] : '0;
endmodule

// File: rtl/rstk_file_chk.sv
module rstk_file_chk #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic             op_ready,
    input logic [2:0]       op_code,
    input logic [PTR_W-1:0] top_ptr,
    input logic             ovf_flag,
    input logic             unf_flag
);
    assert_ready_R12: assert property (@(posedge clk) disable iff (rst)
        op_ready);

    assert_ovf_only_push_R3: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code != 3'd1 |=> !ovf_flag);

    assert_err_hold_R5: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !(ovf_flag || unf_flag) || top_ptr == $past(top_ptr));

    assert_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(ovf_flag && unf_flag));

    assert_push_move_R2: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == 3'd1 |=> ovf_flag || top_ptr == PTR_W'($past(top_ptr) - PTR_W'(1)));

    assert_pop_move_R4: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_code == 3'd2 || op_code == 3'd3 || op_code == 3'd7)
        |=> unf_flag || top_ptr == PTR_W'($past(top_ptr) + PTR_W'(1)));

    assert_no_move_R9: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_code == 3'd0 || op_code == 3'd4 || op_code == 3'd5 || op_code == 3'd6)
        |=> $stable(top_ptr));

    assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !ovf_flag && !unf_flag && $stable(top_ptr));
endmodule

bind rstk_file rstk_file_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_ready (op_ready),
    .op_code  (op_code),
    .top_ptr  (top_ptr),
    .ovf_flag (ovf_flag),
    .unf_flag (unf_flag)
);

// File: tb/rstk_file_tb.sv
`timescale 1ns/1ps
module rstk_file_tb;
    localparam int DEPTH = 8;
    localparam int DW    = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_valid = 1'b0;
    logic          op_ready;
    logic [2:0]    op_code = '0;
    logic [2:0]    op_idx = '0;
    logic [DW-1:0] op_mem = '0;
    logic [2:0]    peek_idx = '0;
    logic [DW-1:0] peek_data;
    logic          peek_full;
    logic [2:0]    top_ptr;
    logic          ovf_flag, unf_flag;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] md [DEPTH];
    bit            mt [DEPTH];
    int            mtop;

    always #2.5 clk = ~clk;

    rstk_file #(.DEPTH(DEPTH), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_code(op_code), .op_idx(op_idx), .op_mem(op_mem),
        .peek_idx(peek_idx), .peek_data(peek_data), .peek_full(peek_full),
        .top_ptr(top_ptr), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    function automatic string req_of(int op);
        case (op)
            1: return "R2";  2: return "R4";  3: return "R6";  4: return "R7";
            5: return "R8";  6: return "R9";  7: return "R10"; default: return "R12";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_op(int op, int idx, logic [DW-1:0] mem, output bit eo, output bit eu);
        int s0 = mtop;
        int si = (mtop + idx) % DEPTH;
        int s1 = (mtop + 1) % DEPTH;
        int sa = (mtop + DEPTH - 1) % DEPTH;
        eo = 0; eu = 0;
        case (op)
            1: if (mt[sa]) eo = 1; else begin mtop = sa; md[sa] = mem; mt[sa] = 1; end
            2: if (!mt[s0]) eu = 1; else begin mt[s0] = 0; mtop = s1; end
            3: if (!mt[s0] || !mt[s1]) eu = 1;
               else begin md[s1] = md[s0] + md[s1]; mt[s0] = 0; mtop = s1; end
            4: if (!mt[s0] || !mt[si]) eu = 1; else md[si] = md[s0] + md[si];
            5: if (!mt[s0]) eu = 1; else md[s0] = md[s0] + mem;
            6: if (!mt[s0] || !mt[si]) eu = 1; else md[s0] = md[s0] + md[si];
            7: if (!mt[s0] || !mt[si]) eu = 1;
               else begin md[si] = md[s0] + md[si]; mt[s0] = 0; mtop = s1; end
            default: ;
        endcase
    endtask

    // Compare every relative slot through the inspection port.
    task automatic check_stack(string req);
        for (int p = 0; p < DEPTH; p++) begin
            int ph = (mtop + p) % DEPTH;
            logic [DW-1:0] ev = mt[ph] ? md[ph] : '0;
            peek_idx = 3'(p);
            #0.1;
            chk(peek_full == mt[ph], req, $sformatf("slot %0d full", p), int'(peek_full), int'(mt[ph]));
            chk(peek_data == ev, req, $sformatf("slot %0d data", p), int'(peek_data), int'(ev));
        end
    endtask

    // Drive on a falling edge, sample 1 ns after the accepting rising edge.
    task automatic do_op(bit v, int op, int idx, logic [DW-1:0] mem, string req = "");
        bit eo, eu;
        string r;
        r = (req == "") ? req_of(op) : req;
        @(negedge clk);
        op_valid = v; op_code = 3'(op); op_idx = 3'(idx); op_mem = mem;
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        eo = 0; eu = 0;
        if (v) model_op(op, idx, mem, eo, eu);
        chk(ovf_flag == eo, eo ? "R3" : r, "ovf_flag", int'(ovf_flag), int'(eo));
        chk(unf_flag == eu, eu ? "R5" : r, "unf_flag", int'(unf_flag), int'(eu));
        chk(int'(top_ptr) == mtop, r, "top_ptr", int'(top_ptr), mtop);
        check_stack(r);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++; n_chk++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int sd;
        sd = $urandom(32'd20211);
        for (int i = 0; i < DEPTH; i++) begin md[i] = '0; mt[i] = 0; end
        mtop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(top_ptr == 3'd0, "R1", "top_ptr", int'(top_ptr), 0);
        chk(!ovf_flag && !unf_flag, "R1", "flags", int'({ovf_flag, unf_flag}), 0);
        chk(op_ready == 1'b1, "R1", "op_ready", int'(op_ready), 1);
        check_stack("R1");

        // R5: empty-stack reads
        do_op(1, 2, 0, '0, "R5");
        do_op(1, 5, 0, 16'h1, "R5");
        do_op(1, 3, 0, '0, "R5");
        // R2/R3: fill then overflow
        for (int i = 0; i < DEPTH; i++) do_op(1, 1, 0, 16'(16'h100 + i), "R2");
        do_op(1, 1, 0, 16'hDEAD, "R3");
        // R12: valid low and code 0 change nothing
        do_op(0, 1, 0, 16'hBEEF, "R12");
        do_op(0, 2, 0, 16'h0, "R12");
        do_op(1, 0, 3, 16'h55, "R12");
        // R7, R9, R8, R6
        do_op(1, 4, 5, '0, "R7");
        do_op(1, 6, 7, '0, "R9");
        do_op(1, 5, 0, 16'h0F0F, "R8");
        do_op(1, 3, 0, '0, "R6");
        // R10 with index 0 discards
        do_op(1, 7, 0, '0, "R10");
        do_op(1, 7, 3, '0, "R10");
        // R11: wrap-around sums
        do_op(1, 1, 0, 16'hFFFF, "R11");
        do_op(1, 5, 0, 16'h0003, "R11");
        do_op(1, 1, 0, 16'h8001, "R11");
        do_op(1, 3, 0, '0, "R11");
        // R4/R5: drain and underflow
        for (int i = 0; i < DEPTH; i++) do_op(1, 2, 0, '0, "R4");
        do_op(1, 7, 2, '0, "R5");

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom % 10);
            int op;
            logic [DW-1:0] mv;
            bit v = ($urandom % 20) != 0;
            case (r)
                0, 1, 2: op = 1;
                3: op = 2;  4: op = 3;  5: op = 4;  6: op = 5;
                7: op = 6;  8: op = 7;  default: op = 0;
            endcase
            mv = (($urandom % 8) == 0) ? 16'hFFFF : DW'($urandom);
            do_op(v, op, int'($urandom % 8), mv);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule